// File: doc/BRIEF.md
# Three-Channel Period Meter with Split-Word Readout

This block measures the period of three slow digital inputs, each of which has already been divided down outside the chip. Every input is brought into the reference clock domain, its rising edges are thinned by an internal programmable prescaler, and the number of reference clock cycles between two consecutive surviving edges is captured as a 32-bit result for that channel.

Software reads a result over a 16-bit data path in two accesses. The low half must be read first. That access also freezes the matching upper half in a per-channel shadow register, and the following upper-half access returns the frozen value, so the two halves always belong to the same capture. When an input stops, or becomes too slow to measure, the running count stops at all ones and that value is published as the result. Host software treats all ones as the slowest input it can report.

Top module: `period_meter`

## Requirements
- R1: For a channel whose input has a constant period of P reference cycles, the captured result settles to PRESCALE*P, the number of reference cycles between consecutive counted edges.
- R2: Only every PRESCALE-th synchronized rising edge of an input closes a measurement. The default PRESCALE is 2.
- R3: The running count stops at all ones and never wraps. Once it reaches all ones, the result becomes all ones without waiting for an input edge, and it stays there until an edge arrives.
- R4: A read with rd_high = 0 returns bits [BUS_W-1:0] of the selected channel's result on rd_data on the clock edge after the access (one cycle latency).
- R5: A read with rd_high = 1 returns the upper half that was frozen by the latest low read of the same channel, even if the result has changed since then. Repeated upper reads without a new low read return the same value.
- R6: The three channels are independent. The period and the reads of one channel do not change another channel's result.
- R7: rd_data keeps its value in cycles with rd_en = 0. A read of a channel index of NUM_CH or more returns zero.
- R8: After reset, every result, every frozen upper half and rd_data are zero.
- R9: A result is recovered after a stall. After saturation, a resumed input again yields PRESCALE*P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that is counted |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_in | input | NUM_CH | Pre-divided asynchronous inputs, one bit per channel |
| rd_en | input | 1 | Read strobe, one access per cycle |
| rd_chan | input | CH_W | Channel index of the access |
| rd_high | input | 1 | 0 = lower half (freezes upper half), 1 = frozen upper half |
| rd_data | output | BUS_W | Registered read data |

## Verification
A read returns its word on the clock edge after the cycle in which rd_en is sampled. The bench raises the strobe at a falling edge and samples rd_data at the next falling edge, which is exactly one register stage later. A change of input period reaches the result only after two synchronizer flops, the edge register and one full new measurement window. The bench therefore waits three windows of the slowest channel plus a few cycles before it reads, and the expected value is PRESCALE times twice the programmed half-period. For saturation the bench stops an input and waits longer than 2^CNT_W cycles in a small configuration (BUS_W = 8). It then reads all ones, waits a further span to show the value does not wrap, and restarts the input.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pm_edge_presc.sv
module pm_edge_presc #(
  parameter int PRESCALE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_async,
  output logic tick_o
);
  logic [1:0] sync_q;
  logic       last_q;
  logic       rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], sig_async};
      last_q <= sync_q[1];
    end
  end

  assign rise = sync_q[1] & ~last_q;

  generate
    if (PRESCALE <= 1) begin : g_nodiv
      assign tick_o = rise;
    end else begin : g_div
      localparam int PC_W = $clog2(PRESCALE);
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);
      logic [PC_W-1:0] pc_q, pc_d;
      logic            pc_en;

      assign pc_en = rise;

      always_comb begin
        pc_d = pc_q;
        if (pc_en) pc_d = (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_en) pc_q <= pc_d;
      end

      assign tick_o = rise && (pc_q == PC_LAST);

      // R2: prescaler state stays inside its ratio
      a_r2_presc_range: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= PC_LAST);
      // R2: two counted edges are never adjacent
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pm_period_cnt.sv
module pm_period_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q, run_d, res_q, res_d, run_inc;
  logic             run_sat;

  assign run_sat = (run_q == CNT_MAX);
  assign run_inc = run_sat ? CNT_MAX : run_q + 1'b1;

  always_comb begin
    run_d = run_inc;
    res_d = res_q;
    if (tick_i) begin
      run_d = '0;
      res_d = run_inc;
    end else if (run_sat) begin
      res_d = CNT_MAX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      res_q <= '0;
    end else begin
      run_q <= run_d;
      res_q <= res_d;
    end
  end

  assign result_o = res_q;

  // R3: the running count does not wrap
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == CNT_MAX) && !tick_i |=> run_q == CNT_MAX);
  // R3: a saturated count is published at once
  a_r3_publish_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == CNT_MAX) |=> result_o == CNT_MAX);
  // R1: the result moves only on a counted edge or saturation
  a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && (run_q != CNT_MAX) |=> $stable(result_o));
  // R1: a counted edge restarts the window
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> run_q == '0);
endmodule

// File: rtl/pm_read_port.sv
module pm_read_port #(
  parameter int NUM_CH = 3,
  parameter int BUS_W  = 16,
  parameter int CNT_W  = 2 * BUS_W,
  parameter int CH_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [CH_W-1:0]              rd_chan,
  input  logic                         rd_high,
  input  logic [NUM_CH-1:0][CNT_W-1:0] result_i,
  output logic [BUS_W-1:0]             rd_data
);
  import pm_pkg::*;

  logic [NUM_CH-1:0][BUS_W-1:0] shd_q, shd_d;
  logic [BUS_W-1:0]             data_q, data_d;
  logic                         chan_ok;
  half_sel_e                    sel;

  assign chan_ok = (int'(rd_chan) < NUM_CH);
  assign sel     = half_sel_e'(rd_high);

  always_comb begin
    shd_d  = shd_q;
    data_d = data_q;
    if (rd_en) begin
      data_d = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (chan_ok && int'(rd_chan) == c) begin
          if (sel == HALF_LO) begin
            data_d   = result_i[c][BUS_W-1:0];
            shd_d[c] = result_i[c][CNT_W-1:BUS_W];
          end else begin
            data_d = shd_q[c];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      data_q <= '0;
    end else if (rd_en) begin
      shd_q  <= shd_d;
      data_q <= data_d;
    end
  end

  assign rd_data = data_q;

  // R7: idle bus keeps its data
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R7: out-of-range channel reads zero
  a_r7_bad_chan: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (int'(rd_chan) >= NUM_CH) |=> rd_data == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5: a low read freezes the matching upper half
    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !rd_high && (int'(rd_chan) == c)
      |=> shd_q[c] == $past(result_i[c][CNT_W-1:BUS_W]));
    // R4: a low read returns the lower half
    a_r4_low_word: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !rd_high && (int'(rd_chan) == c)
      |=> rd_data == $past(result_i[c][BUS_W-1:0]));
    // R5: an upper read returns the frozen half
    a_r5_high_word: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_high && (int'(rd_chan) == c)
      |=> rd_data == $past(shd_q[c]));
  end
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int NUM_CH   = 3,
  parameter int BUS_W    = 16,
  parameter int PRESCALE = 2,
  localparam int CNT_W   = 2 * BUS_W,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) + ((NUM_CH & (NUM_CH - 1)) == 0 ? 1 : 0) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sig_in,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_chan,
  input  logic              rd_high,
  output logic [BUS_W-1:0]  rd_data
);
  logic                         rst_core_n;
  logic [NUM_CH-1:0]            tick;
  logic [NUM_CH-1:0][CNT_W-1:0] result;

  pm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pm_edge_presc #(.PRESCALE(PRESCALE)) u_edge (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .sig_async (sig_in[c]),
      .tick_o    (tick[c])
    );

    pm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .tick_i   (tick[c]),
      .result_o (result[c])
    );
  end

  pm_read_port #(
    .NUM_CH (NUM_CH),
    .BUS_W  (BUS_W),
    .CNT_W  (CNT_W),
    .CH_W   (CH_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_en    (rd_en),
    .rd_chan  (rd_chan),
    .rd_high  (rd_high),
    .result_i (result),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/test_period_meter.sv
module test_period_meter;
  localparam int NCH  = 3;
  localparam int BW   = 8;
  localparam int PS   = 2;
  localparam int CW   = 2;
  localparam int MAXW = (1 << BW) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] sig = '0;
  logic           rd_en = 1'b0;
  logic [CW-1:0]  rd_chan = '0;
  logic           rd_high = 1'b0;
  logic [BW-1:0]  rd_data;

  int half [NCH];
  int gcnt [NCH];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  period_meter #(.NUM_CH(NCH), .BUS_W(BW), .PRESCALE(PS)) i_period_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig_in  (sig),
    .rd_en   (rd_en),
    .rd_chan (rd_chan),
    .rd_high (rd_high),
    .rd_data (rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int ch, input bit hi, output int v);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_chan = CW'(ch);
    rd_high = hi;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      half[c] = 0;
      gcnt[c] = 0;
    end
    forever begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (half[c] != 0) begin
          gcnt[c]++;
          if (gcnt[c] >= half[c]) begin
            sig[c]  = ~sig[c];
            gcnt[c] = 0;
          end
        end
      end
    end
  end

  initial begin
    int v, lo, hi, exp, mx;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    check("R8 rd_data after reset", int'(rd_data), 0);
    for (int c = 0; c < NCH; c++) begin
      rd(c, 1'b0, v); check("R8 low half after reset", v, 0);
      rd(c, 1'b1, v); check("R8 high half after reset", v, 0);
    end

    // R1 R2 R4 R6: sweep distinct periods on all channels
    for (int h = 2; h <= 60; h++) begin
      half[0] = h; half[1] = h + 1; half[2] = 2 * h + 3;
      mx = 2 * h + 3;
      idle(3 * 2 * PS * mx + 8);
      for (int c = 0; c < NCH; c++) begin
        exp = PS * 2 * half[c];
        rd(c, 1'b0, lo);
        rd(c, 1'b1, hi);
        check("R1 R2 R6 period low half", lo, exp & MAXW);
        check("R1 R4 period high half", hi, (exp >> BW) & MAXW);
      end
    end

    // R7: idle bus holds, bad channel reads zero
    rd(0, 1'b0, v);
    idle(20);
    check("R7 hold while idle", int'(rd_data), v);
    rd(3, 1'b0, v); check("R7 bad channel low", v, 0);
    rd(3, 1'b1, v); check("R7 bad channel high", v, 0);

    // R5: coherence across a change of result
    half[0] = 100;
    idle(3 * 2 * PS * 123 + 8);
    rd(0, 1'b0, lo); check("R5 first low", lo, 400 & MAXW);
    half[0] = 200;
    idle(3 * 2 * PS * 200 + 8);
    rd(0, 1'b1, hi); check("R5 high keeps frozen half", hi, 400 >> BW);
    rd(0, 1'b1, hi); check("R5 repeated high", hi, 400 >> BW);
    rd(0, 1'b0, lo); check("R5 new low", lo, 800 & MAXW);
    rd(0, 1'b1, hi); check("R5 new high", hi, 800 >> BW);

    // R3: stall channel 1, saturate, no wrap; R6 others unaffected
    half[1] = 0;
    idle(1 << (2 * BW));
    idle(300);
    rd(1, 1'b0, lo); check("R3 saturated low", lo, MAXW);
    rd(1, 1'b1, hi); check("R3 saturated high", hi, MAXW);
    idle(5000);
    rd(1, 1'b0, lo); check("R3 no wrap low", lo, MAXW);
    rd(1, 1'b1, hi); check("R3 no wrap high", hi, MAXW);
    rd(2, 1'b0, lo); check("R6 neighbour low", lo, (PS * 2 * half[2]) & MAXW);
    rd(2, 1'b1, hi); check("R6 neighbour high", hi, (PS * 2 * half[2]) >> BW);

    // R9: recovery after stall
    half[1] = 7;
    idle(3 * 2 * PS * 7 + 8);
    rd(1, 1'b0, lo); check("R9 recovered low", lo, PS * 2 * 7);
    rd(1, 1'b1, hi); check("R9 recovered high", hi, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule